// File: doc/BRIEF.md
# UART Queue Status and Interrupt Logic

This block holds the transmit and receive byte queues of a UART data path and keeps the status flags and interrupt lines that software uses to drive them. On the CPU side, a write pushes a byte into the transmit queue and a read pops the oldest byte from the receive queue. On the line side, a valid/ready pair drains transmit bytes toward the serializer, and a second valid/ready pair accepts received bytes from the deserializer.

The flag set is receive empty, receive full, transmit empty, transmit full and a busy indication. Busy goes high only when the transmit queue fills and drops as soon as one slot opens, so a driver can stream bytes without polling before each one. The raw transmit interrupt uses a half-FIFO trigger based on a nominal 32-entry FIFO. It is high only while at least 16 transmit slots are free, which means a driver that answers it can always write a burst of 16 bytes without loss. A two-bit mask gates the raw interrupts onto one combined interrupt line. Two sticky error bits record a write dropped because the transmit queue was full and a read made while the receive queue was empty.

Top module: `uart_status_core`

## Requirements
- R1: After reset, both queues are empty. flag_tx_empty, flag_rx_empty and raw_tx_irq are 1. flag_tx_full, flag_rx_full, flag_busy, raw_rx_irq, both error bits, irq_mask and irq are 0.
- R2: Bytes written by the CPU leave on tx_data in the order they were written. tx_valid is 1 exactly when the transmit queue holds a byte, and a byte is removed on each cycle with tx_valid and tx_ready both 1.
- R3: flag_tx_empty is 0 from the clock edge that accepts a write until the edge that removes the last transmit byte, and is 1 again after that edge.
- R4: flag_tx_full and flag_busy both become 1 at the edge where the transmit queue reaches TX_DEPTH entries. Both return to 0 at the first edge that drains an entry.
- R5: raw_tx_irq is 1 exactly when the transmit occupancy is at most TX_DEPTH minus 16. It is re-evaluated at every edge where a write or a drain changes the occupancy.
- R6: rx_ready is 1 exactly when the receive queue is not full. A byte on rx_data is stored when rx_valid and rx_ready are both 1. cpu_rd_data shows the oldest stored byte, and bytes are read back in arrival order.
- R7: raw_rx_irq is 1 and flag_rx_empty is 0 whenever the receive queue holds at least one byte. Both return to their empty values at the edge of the read that removes the last byte.
- R8: flag_rx_full is 1 exactly when the receive queue holds RX_DEPTH bytes. Any accepted read clears it.
- R9: A CPU write while flag_tx_full is 1 is dropped, leaves the queue contents unchanged and sets err_tx_overrun, which stays 1 until reset.
- R10: A CPU read while flag_rx_empty is 1 removes nothing and sets err_rx_underrun, which stays 1 until reset.
- R11: irq equals (raw_tx_irq AND irq_mask bit 0) OR (raw_rx_irq AND irq_mask bit 1), in the same cycle. A mask_wr_en cycle loads mask_wr_data into irq_mask at the clock edge.
- R12: In one cycle, a write and a drain both take effect when the queue is not full, leaving the occupancy unchanged. A write is still dropped when flag_tx_full was 1 at that edge, even if a drain happens in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr_en | input | 1 | CPU data write strobe |
| cpu_wr_data | input | 8 | Byte to queue for transmit |
| cpu_rd_en | input | 1 | CPU data read strobe |
| cpu_rd_data | output | 8 | Oldest received byte |
| mask_wr_en | input | 1 | Load the interrupt mask |
| mask_wr_data | input | 2 | New mask, bit 0 TX, bit 1 RX |
| irq_mask | output | 2 | Current interrupt mask |
| tx_valid | output | 1 | Transmit byte available |
| tx_data | output | 8 | Oldest transmit byte |
| tx_ready | input | 1 | Line side takes the transmit byte |
| rx_valid | input | 1 | Line side offers a received byte |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Receive queue can take a byte |
| flag_rx_empty | output | 1 | Receive queue empty |
| flag_rx_full | output | 1 | Receive queue full |
| flag_tx_empty | output | 1 | Transmit queue empty |
| flag_tx_full | output | 1 | Transmit queue full |
| flag_busy | output | 1 | Transmit queue full, writes must wait |
| raw_tx_irq | output | 1 | At least 16 transmit slots free |
| raw_rx_irq | output | 1 | Received data available |
| err_tx_overrun | output | 1 | Sticky: write dropped on full queue |
| err_rx_underrun | output | 1 | Sticky: read on empty queue |
| irq | output | 1 | Combined masked interrupt |

## Verification
All flags, raw interrupts, error bits and the mask are registers that change at the edge that accepts the causing access, so they are due one edge after the stimulus is applied. The bench compares them just after that edge against a model updated at the same point. tx_valid, tx_data, rx_ready, cpu_rd_data and irq depend on registered state only through gates, so they are compared in the same cycle, after inputs settle and before the edge that consumes them. Directed sequences walk the transmit occupancy across the 16/17 boundary, to full, and through a simultaneous drain and write. Randomized phases then alternate write-heavy and drain-heavy traffic so that every flag toggles many times.

// File: rtl/uart_stat_pkg.sv
package uart_stat_pkg;
  // nominal FIFO size that sets the transmit interrupt trigger
  localparam int NOMINAL_FIFO = 32;
  localparam int TX_TRIG_FREE = NOMINAL_FIFO / 2;
  // interrupt mask bit positions
  localparam int IRQ_TX_BIT = 0;
  localparam int IRQ_RX_BIT = 1;
  localparam int IRQ_W      = 2;
endpackage

// File: rtl/byte_queue.sv
module byte_queue #(
  parameter int DEPTH = 32,
  parameter int W     = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head_data,
  output logic [CW-1:0] count,
  output logic [CW-1:0] count_nxt
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, wr_ptr_nxt;
  logic [PW-1:0] rd_ptr, rd_ptr_nxt;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_ptr_nxt = wr_ptr;
    rd_ptr_nxt = rd_ptr;
    count_nxt  = count;
    if (push) wr_ptr_nxt = bump(wr_ptr);
    if (pop)  rd_ptr_nxt = bump(rd_ptr);
    case ({push, pop})
      2'b10:   count_nxt = count + 1'b1;
      2'b01:   count_nxt = count - 1'b1;
      default: count_nxt = count;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push)        wr_ptr <= wr_ptr_nxt;
      if (pop)         rd_ptr <= rd_ptr_nxt;
      if (push || pop) count  <= count_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  assign head_data = mem[rd_ptr];

  // the enclosing logic must never push into a full queue
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (count != CW'(DEPTH)));
  // the enclosing logic must never pop an empty queue
  p_no_underflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (count != '0));
endmodule

// File: rtl/queue_flags.sv
module queue_flags #(
  parameter int DEPTH = 32,
  parameter int CW    = $clog2(DEPTH + 1),
  parameter bit IS_TX = 1'b1,
  parameter int TRIG  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count_nxt,
  input  logic          bad_access,
  output logic          empty,
  output logic          full,
  output logic          busy,
  output logic          raw_irq,
  output logic          err
);
  localparam logic RAW_RST = IS_TX ? 1'b1 : 1'b0;

  logic empty_nxt, full_nxt, busy_nxt, raw_nxt, err_nxt;

  always_comb begin
    empty_nxt = (count_nxt == '0);
    full_nxt  = (count_nxt == CW'(DEPTH));
    err_nxt   = err | bad_access;
  end

  generate
    if (IS_TX) begin : g_tx
      // half-FIFO trigger: enough free slots for a full burst
      always_comb begin
        raw_nxt  = (count_nxt <= CW'(DEPTH - TRIG));
        busy_nxt = full_nxt;
      end
    end else begin : g_rx
      always_comb begin
        raw_nxt  = !empty_nxt;
        busy_nxt = 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty   <= 1'b1;
      full    <= 1'b0;
      busy    <= 1'b0;
      raw_irq <= RAW_RST;
      err     <= 1'b0;
    end else begin
      empty   <= empty_nxt;
      full    <= full_nxt;
      busy    <= busy_nxt;
      raw_irq <= raw_nxt;
      if (bad_access) err <= err_nxt;
    end
  end

  p_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && full));
  p_busy_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> full);
  p_err_sticky_r9_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
endmodule

// File: rtl/uart_status_core.sv
module uart_status_core #(
  parameter int TX_DEPTH = 32,
  parameter int RX_DEPTH = 32,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr_en,
  input  logic [DATA_W-1:0] cpu_wr_data,
  input  logic              cpu_rd_en,
  output logic [DATA_W-1:0] cpu_rd_data,
  input  logic              mask_wr_en,
  input  logic [1:0]        mask_wr_data,
  output logic [1:0]        irq_mask,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  input  logic              tx_ready,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              flag_rx_empty,
  output logic              flag_rx_full,
  output logic              flag_tx_empty,
  output logic              flag_tx_full,
  output logic              flag_busy,
  output logic              raw_tx_irq,
  output logic              raw_rx_irq,
  output logic              err_tx_overrun,
  output logic              err_rx_underrun,
  output logic              irq
);
  import uart_stat_pkg::*;

  localparam int TXCW = $clog2(TX_DEPTH + 1);
  localparam int RXCW = $clog2(RX_DEPTH + 1);

  generate
    if (TX_DEPTH < TX_TRIG_FREE) begin : g_depth_check
      initial $error("TX_DEPTH below the half-FIFO trigger level");
    end
  endgenerate

  logic            tx_push, tx_pop, tx_drop;
  logic            rx_push, rx_pop, rx_drop;
  logic [TXCW-1:0] tx_count, tx_count_nxt;
  logic [RXCW-1:0] rx_count, rx_count_nxt;
  logic            rx_busy_unused;
  logic [1:0]      mask_nxt;

  // access qualification against the registered flags
  always_comb begin
    tx_push  = cpu_wr_en & ~flag_tx_full;
    tx_drop  = cpu_wr_en &  flag_tx_full;
    tx_pop   = tx_valid & tx_ready;
    rx_push  = rx_valid & rx_ready;
    rx_pop   = cpu_rd_en & ~flag_rx_empty;
    rx_drop  = cpu_rd_en &  flag_rx_empty;
  end

  assign tx_valid = ~flag_tx_empty;
  assign rx_ready = ~flag_rx_full;

  byte_queue #(.DEPTH(TX_DEPTH), .W(DATA_W), .CW(TXCW)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .push(tx_push), .push_data(cpu_wr_data), .pop(tx_pop),
    .head_data(tx_data), .count(tx_count), .count_nxt(tx_count_nxt)
  );

  byte_queue #(.DEPTH(RX_DEPTH), .W(DATA_W), .CW(RXCW)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .push(rx_push), .push_data(rx_data), .pop(rx_pop),
    .head_data(cpu_rd_data), .count(rx_count), .count_nxt(rx_count_nxt)
  );

  queue_flags #(.DEPTH(TX_DEPTH), .CW(TXCW), .IS_TX(1'b1), .TRIG(TX_TRIG_FREE)) u_txf (
    .clk(clk), .rst_n(rst_n), .count_nxt(tx_count_nxt), .bad_access(tx_drop),
    .empty(flag_tx_empty), .full(flag_tx_full), .busy(flag_busy),
    .raw_irq(raw_tx_irq), .err(err_tx_overrun)
  );

  queue_flags #(.DEPTH(RX_DEPTH), .CW(RXCW), .IS_TX(1'b0), .TRIG(TX_TRIG_FREE)) u_rxf (
    .clk(clk), .rst_n(rst_n), .count_nxt(rx_count_nxt), .bad_access(rx_drop),
    .empty(flag_rx_empty), .full(flag_rx_full), .busy(rx_busy_unused),
    .raw_irq(raw_rx_irq), .err(err_rx_underrun)
  );

  // interrupt mask register
  always_comb begin
    mask_nxt = irq_mask;
    if (mask_wr_en) mask_nxt = mask_wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          irq_mask <= '0;
    else if (mask_wr_en) irq_mask <= mask_nxt;
  end

  assign irq = (raw_tx_irq & irq_mask[IRQ_TX_BIT]) | (raw_rx_irq & irq_mask[IRQ_RX_BIT]);

  p_txirq_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    raw_tx_irq == (tx_count <= TXCW'(TX_DEPTH - TX_TRIG_FREE)));
  p_rxirq_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    raw_rx_irq != flag_rx_empty);
  p_rxfull_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flag_rx_full == (rx_count == RXCW'(RX_DEPTH)));
  p_drop_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr_en && flag_tx_full && !tx_ready) |=> flag_tx_full);
  p_busy_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_busy && tx_ready) |=> !flag_busy);
endmodule

// File: tb/sim_uart_status_core.sv
module sim_uart_status_core;
  localparam int CLK_PERIOD = 10;
  localparam int TXD  = 32;
  localparam int RXD  = 32;
  localparam int TRIG = 16;

  logic       clk, rst_n;
  logic       cpu_wr_en, cpu_rd_en, mask_wr_en, tx_ready, rx_valid;
  logic [7:0] cpu_wr_data, cpu_rd_data, tx_data, rx_data;
  logic [1:0] mask_wr_data, irq_mask;
  logic       tx_valid, rx_ready;
  logic       flag_rx_empty, flag_rx_full, flag_tx_empty, flag_tx_full, flag_busy;
  logic       raw_tx_irq, raw_rx_irq, err_tx_overrun, err_rx_underrun, irq;

  uart_status_core #(.TX_DEPTH(TXD), .RX_DEPTH(RXD), .DATA_W(8)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cpu_wr_en(cpu_wr_en), .cpu_wr_data(cpu_wr_data),
    .cpu_rd_en(cpu_rd_en), .cpu_rd_data(cpu_rd_data),
    .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data), .irq_mask(irq_mask),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .flag_rx_empty(flag_rx_empty), .flag_rx_full(flag_rx_full),
    .flag_tx_empty(flag_tx_empty), .flag_tx_full(flag_tx_full), .flag_busy(flag_busy),
    .raw_tx_irq(raw_tx_irq), .raw_rx_irq(raw_rx_irq),
    .err_tx_overrun(err_tx_overrun), .err_rx_underrun(err_rx_underrun), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;

  // bench model state
  logic [7:0] mtx [TXD];
  logic [7:0] mrx [RXD];
  int mtx_h = 0, mtx_c = 0, mrx_h = 0, mrx_c = 0;
  bit m_ovr = 0, m_und = 0;
  logic [1:0] m_mask = 2'b00;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_raw_tx(input int c);
    return (c <= TXD - TRIG) ? 1 : 0;
  endfunction

  function automatic int exp_irq(input int tc, input int rc, input logic [1:0] m);
    return ((exp_raw_tx(tc) != 0 && m[0]) || (rc != 0 && m[1])) ? 1 : 0;
  endfunction

  task automatic check_regs();
    chk("R3 flag_tx_empty", int'(flag_tx_empty), (mtx_c == 0) ? 1 : 0);
    chk("R4 flag_tx_full", int'(flag_tx_full), (mtx_c == TXD) ? 1 : 0);
    chk("R4 flag_busy", int'(flag_busy), (mtx_c == TXD) ? 1 : 0);
    chk("R5 raw_tx_irq", int'(raw_tx_irq), exp_raw_tx(mtx_c));
    chk("R7 raw_rx_irq", int'(raw_rx_irq), (mrx_c != 0) ? 1 : 0);
    chk("R7 flag_rx_empty", int'(flag_rx_empty), (mrx_c == 0) ? 1 : 0);
    chk("R8 flag_rx_full", int'(flag_rx_full), (mrx_c == RXD) ? 1 : 0);
    chk("R9 err_tx_overrun", int'(err_tx_overrun), int'(m_ovr));
    chk("R10 err_rx_underrun", int'(err_rx_underrun), int'(m_und));
    chk("R11 irq_mask", int'(irq_mask), int'(m_mask));
    chk("R11 irq", int'(irq), exp_irq(mtx_c, mrx_c, m_mask));
  endtask

  task automatic step(input bit wr, input logic [7:0] wd, input bit rd, input bit txr,
                      input bit rxv, input logic [7:0] rxd, input bit mw, input logic [1:0] md);
    bit wr_ok, drain, rd_ok, push;
    int tail;
    @(negedge clk);
    cpu_wr_en = wr; cpu_wr_data = wd; cpu_rd_en = rd; tx_ready = txr;
    rx_valid = rxv; rx_data = rxd; mask_wr_en = mw; mask_wr_data = md;
    #1;
    chk("R2 tx_valid", int'(tx_valid), (mtx_c != 0) ? 1 : 0);
    if (mtx_c != 0) chk("R2 tx_data order", int'(tx_data), int'(mtx[mtx_h]));
    chk("R6 rx_ready", int'(rx_ready), (mrx_c != RXD) ? 1 : 0);
    if (mrx_c != 0) chk("R6 cpu_rd_data order", int'(cpu_rd_data), int'(mrx[mrx_h]));
    chk("R11 irq comb", int'(irq), exp_irq(mtx_c, mrx_c, m_mask));
    wr_ok = wr && (mtx_c != TXD);
    drain = (mtx_c != 0) && txr;
    rd_ok = rd && (mrx_c != 0);
    push  = rxv && (mrx_c != RXD);
    @(posedge clk);
    tail = (mtx_h + mtx_c) % TXD;
    if (wr_ok) mtx[tail] = wd;
    if (drain) mtx_h = (mtx_h + 1) % TXD;
    mtx_c = mtx_c + int'(wr_ok) - int'(drain);
    if (wr && !wr_ok) m_ovr = 1;
    tail = (mrx_h + mrx_c) % RXD;
    if (push) mrx[tail] = rxd;
    if (rd_ok) mrx_h = (mrx_h + 1) % RXD;
    mrx_c = mrx_c + int'(push) - int'(rd_ok);
    if (rd && !rd_ok) m_und = 1;
    if (mw) m_mask = md;
    #1;
    check_regs();
  endtask

  task automatic idle();
    step(0, 8'h00, 0, 0, 0, 8'h00, 0, 2'b00);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed_init;
    rst_n = 1'b0;
    cpu_wr_en = 0; cpu_wr_data = 0; cpu_rd_en = 0; mask_wr_en = 0; mask_wr_data = 0;
    tx_ready = 0; rx_valid = 0; rx_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 tx_empty", int'(flag_tx_empty), 1);
    chk("R1 rx_empty", int'(flag_rx_empty), 1);
    chk("R1 raw_tx_irq", int'(raw_tx_irq), 1);
    chk("R1 tx_full", int'(flag_tx_full), 0);
    chk("R1 rx_full", int'(flag_rx_full), 0);
    chk("R1 busy", int'(flag_busy), 0);
    chk("R1 raw_rx_irq", int'(raw_rx_irq), 0);
    chk("R1 errors", int'({err_tx_overrun, err_rx_underrun}), 0);
    chk("R1 irq_mask", int'(irq_mask), 0);
    chk("R1 irq", int'(irq), 0);

    // transmit fill across the half-FIFO boundary to full
    step(0, 0, 0, 0, 0, 0, 1, 2'b01);
    for (int i = 0; i < TXD; i++) begin
      step(1, 8'(8'h40 + i), 0, 0, 0, 0, 0, 2'b00);
      if (i == TRIG - 1) chk("R5 raw_tx at 16 used", int'(raw_tx_irq), 1);
      if (i == TRIG)     chk("R5 raw_tx at 17 used", int'(raw_tx_irq), 0);
    end
    chk("R4 busy at full", int'(flag_busy), 1);
    // write and drain together while full: write dropped
    step(1, 8'hEE, 0, 1, 0, 0, 0, 2'b00);
    chk("R12 drop despite drain", int'(err_tx_overrun), 1);
    chk("R12 full cleared by drain", int'(flag_tx_full), 0);
    // write and drain together when not full
    step(1, 8'h99, 0, 1, 0, 0, 0, 2'b00);
    chk("R12 occupancy kept", int'(flag_tx_full), 0);
    step(1, 8'h9A, 0, 0, 0, 0, 0, 2'b00);
    step(1, 8'h9B, 0, 0, 0, 0, 0, 2'b00);
    chk("R9 write on full dropped", int'(flag_tx_full), 1);
    // drain everything
    while (mtx_c != 0) step(0, 0, 0, 1, 0, 0, 0, 2'b00);
    chk("R3 tx_empty after drain", int'(flag_tx_empty), 1);

    // receive fill to full, extra offer refused, then empty and underrun
    step(0, 0, 0, 0, 0, 0, 1, 2'b10);
    for (int i = 0; i < RXD + 2; i++) step(0, 0, 0, 0, 1, 8'(8'hA0 + i), 0, 2'b00);
    chk("R8 rx full", int'(flag_rx_full), 1);
    step(0, 0, 1, 0, 0, 0, 0, 2'b00);
    chk("R8 rx full cleared by read", int'(flag_rx_full), 0);
    while (mrx_c != 0) step(0, 0, 1, 0, 0, 0, 0, 2'b00);
    chk("R7 rx empty after last read", int'(flag_rx_empty), 1);
    step(0, 0, 1, 0, 0, 0, 0, 2'b00);
    chk("R10 underrun sticky", int'(err_rx_underrun), 1);
    idle();

    // randomized phases
    seed_init = $urandom(32'h5A17);
    for (int ph = 0; ph < 16; ph++) begin
      for (int n = 0; n < 250; n++) begin
        int wp, dp;
        wp = ph[0] ? 80 : 30;
        dp = ph[0] ? 30 : 80;
        step(($urandom % 100) < wp, 8'($urandom), ($urandom % 100) < dp,
             ($urandom % 100) < dp, ($urandom % 100) < wp, 8'($urandom),
             ($urandom % 50) == 0, 2'($urandom));
      end
    end
    idle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule